// File: doc/BRIEF.md
# DAC Power-State and Clear Controller

This block decides when a 12-bit voltage DAC is powered down and what code its registers fall back to. It watches a hardware power-down pin, a lockout pin that can forbid power-down, an active-low clear pin and a pin that chooses the fallback code. It also takes one-cycle sleep and wake pulses from the serial command decoder. A wake pulse stands for any command that writes the DAC register.

Its outputs are as follows. A shutdown flag puts the analog output into high impedance and also freezes the serial data-out and user output pins. Clear strobes go to the input register, the DAC register and the user output. The fallback code is driven out. A ready flag models the settling of the reference after each wake-up, and it stays low for a parameter-set number of cycles.

Entry into shutdown and exit from it follow different rules. Power-down is entered through the pin or a sleep command, but only while lockout is high. Releasing the pin does not end it. Shutdown ends only on a falling edge of lockout, a wake command or a clear.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: With `lock_pin` high and `pd_pin` high, and no exit event present, `shut` and `hold` are 1 after the next clock edge.
- R2: Driving `pd_pin` back low leaves `shut` at 1. Without an exit event, shutdown persists.
- R3: While `lock_pin` is low, neither `pd_pin` nor `cmd_sleep` sets `shut`. A rising edge on `lock_pin` has no effect on `shut`.
- R4: A 1-to-0 transition of `lock_pin`, seen between two consecutive clock edges, clears `shut` at the second edge.
- R5: A `cmd_wake` pulse clears `shut` at the next edge.
- R6: `clr_n` low clears `shut` at the next edge. While `clr_n` is low, `clr_dac_reg` is 1.
- R7: `rst_code` is 0x000 when `rst_mid` is 0 and 0x800 (midscale) when `rst_mid` is 1.
- R8: From reset until the first clock edge after `rst_n` rises, `clr_in_reg` and `clr_dac_reg` are both 1. After that edge they are 0 while `clr_n` is high. Out of reset, `shut` is 0 and `ready` is 1.
- R9: When `clr_n` is low while `shut` is 1, `clr_upo` is 1 for the one cycle that follows the edge that ends shutdown. A wake that does not involve clear leaves `clr_upo` at 0.
- R10: After any edge that ends shutdown, `ready` is 0 for exactly SETTLE_CYCLES cycles and then returns to 1. While `shut` is 1, `ready` is 0.
- R11: When an entry request and an exit event occur in the same cycle, the exit wins and `shut` is 0 after the edge.
- R12: A `cmd_sleep` pulse with `lock_pin` high sets `shut` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| pd_pin | input | 1 | Hardware power-down request, level |
| lock_pin | input | 1 | Lockout; low forbids shutdown, falling edge wakes |
| clr_n | input | 1 | Active-low clear |
| rst_mid | input | 1 | Fallback code select: 0 zero, 1 midscale |
| cmd_sleep | input | 1 | Sleep command pulse from decoder |
| cmd_wake | input | 1 | DAC-updating command pulse from decoder |
| shut | output | 1 | Shutdown flag, analog output high impedance |
| hold | output | 1 | Freeze data-out and user output |
| rst_code | output | 12 | Fallback code for the registers |
| clr_in_reg | output | 1 | Load input register with fallback code |
| clr_dac_reg | output | 1 | Load DAC register with fallback code |
| clr_upo | output | 1 | Return user output to its default low |
| ready | output | 1 | Reference settled |

## Verification
Entry into shutdown and exit from it can land on the same edge. The bench provokes this in three ways: a level power-down request together with a wake command while already awake, the same pair while asleep, and a sleep command together with a wake command. Each case is judged by `shut` being 0 one edge later. The case with the power-down pin held high must show shutdown again on the following edge, which confirms that the exit won only for that cycle.

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl #(
  parameter int W             = 12,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pd_pin,
  input  logic         lock_pin,
  input  logic         clr_n,
  input  logic         rst_mid,
  input  logic         cmd_sleep,
  input  logic         cmd_wake,
  output logic         shut,
  output logic         hold,
  output logic [W-1:0] rst_code,
  output logic         clr_in_reg,
  output logic         clr_dac_reg,
  output logic         clr_upo,
  output logic         ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);

  logic          lock_q, boot, shut_q, upo_q;
  logic [CW-1:0] cnt;
  logic          lock_fall, exit_ev, enter_ev;

  assign lock_fall = lock_q & ~lock_pin;
  assign exit_ev   = lock_fall | cmd_wake | ~clr_n;
  assign enter_ev  = lock_pin & (pd_pin | cmd_sleep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      boot   <= 1'b1;
      shut_q <= 1'b0;
      upo_q  <= 1'b0;
      cnt    <= '0;
    end else begin
      lock_q <= lock_pin;
      boot   <= 1'b0;
      upo_q  <= shut_q & ~clr_n;
      if (exit_ev)       shut_q <= 1'b0;
      else if (enter_ev) shut_q <= 1'b1;
      if (shut_q && exit_ev) cnt <= LOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
    end
  end

  assign shut        = shut_q;
  assign hold        = shut_q;
  assign rst_code    = rst_mid ? MID : '0;
  assign clr_in_reg  = boot;
  assign clr_dac_reg = boot | ~clr_n;
  assign clr_upo     = upo_q;
  assign ready       = ~shut_q && (cnt == '0);
endmodule

// File: rtl/dac_pwr_ctrl_chk.sv
module dac_pwr_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_pin,
  input logic lock_pin,
  input logic clr_n,
  input logic cmd_sleep,
  input logic cmd_wake,
  input logic shut,
  input logic clr_upo,
  input logic ready
);
  logic lk_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lk_prev <= 1'b0;
    else        lk_prev <= lock_pin;

  logic no_exit;
  assign no_exit = clr_n && !cmd_wake && !(lk_prev && !lock_pin);

  assert_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pin && pd_pin && no_exit |=> shut);
  assert_persist_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shut && no_exit |=> shut);
  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_pin && !shut |=> !shut);
  assert_lockfall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prev && !lock_pin |=> !shut);
  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wake |=> !shut);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !shut);
  assert_upo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shut && !clr_n |=> clr_upo);
  assert_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut) |-> !ready);
  assert_sleep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pin && cmd_sleep && no_exit |=> shut);
endmodule

bind dac_pwr_ctrl dac_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .lock_pin(lock_pin),
  .clr_n(clr_n), .cmd_sleep(cmd_sleep), .cmd_wake(cmd_wake),
  .shut(shut), .clr_upo(clr_upo), .ready(ready)
);

// File: tb/sim_dac_pwr_ctrl.sv
module sim_dac_pwr_ctrl;
  localparam int W = 12;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n, pd_pin, lock_pin, clr_n, rst_mid, cmd_sleep, cmd_wake;
  logic shut, hold, clr_in_reg, clr_dac_reg, clr_upo, ready;
  logic [W-1:0] rst_code;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dac_pwr_ctrl #(.W(W), .SETTLE_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .lock_pin(lock_pin),
    .clr_n(clr_n), .rst_mid(rst_mid), .cmd_sleep(cmd_sleep),
    .cmd_wake(cmd_wake), .shut(shut), .hold(hold), .rst_code(rst_code),
    .clr_in_reg(clr_in_reg), .clr_dac_reg(clr_dac_reg),
    .clr_upo(clr_upo), .ready(ready)
  );

  // {req, pd, lock, clr_n, sleep, wake, expected shut}
  localparam logic [9:0] VEC [16] = '{
    {4'd1,  6'b0_1_1_0_0_0},  // R1 idle awake
    {4'd1,  6'b1_1_1_0_0_1},  // R1 pin enters
    {4'd2,  6'b0_1_1_0_0_1},  // R2 pin release keeps shutdown
    {4'd5,  6'b0_1_1_0_1_0},  // R5 wake command
    {4'd12, 6'b0_1_1_1_0_1},  // R12 sleep command
    {4'd4,  6'b0_0_1_0_0_0},  // R4 lockout falls
    {4'd3,  6'b1_0_1_0_0_0},  // R3 pin ignored
    {4'd3,  6'b0_0_1_1_0_0},  // R3 sleep ignored
    {4'd3,  6'b0_1_1_0_0_0},  // R3 lockout rise no effect
    {4'd11, 6'b1_1_1_0_1_0},  // R11 pin+wake while awake
    {4'd1,  6'b1_1_1_0_0_1},  // R1 enter
    {4'd11, 6'b1_1_1_0_1_0},  // R11 pin+wake while asleep
    {4'd11, 6'b0_1_1_1_1_0},  // R11 sleep+wake
    {4'd12, 6'b0_1_1_1_0_1},  // R12 enter by command
    {4'd6,  6'b0_1_0_0_0_0},  // R6 clear wakes
    {4'd6,  6'b0_1_1_0_0_0}   // R6 stays awake
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pd_pin = 0; cmd_sleep = 0; cmd_wake = 0; clr_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; lock_pin = 1; rst_mid = 0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R8 clr_in_reg at boot", W'(clr_in_reg), 1);
    chk("R8 clr_dac_reg at boot", W'(clr_dac_reg), 1);
    chk("R8 shut at boot", W'(shut), 0);
    chk("R8 ready at boot", W'(ready), 1);
    @(negedge clk);
    chk("R8 clr_in_reg after edge", W'(clr_in_reg), 0);
    chk("R8 clr_dac_reg after edge", W'(clr_dac_reg), 0);

    for (int i = 0; i < 16; i++) begin
      {pd_pin, lock_pin, clr_n, cmd_sleep, cmd_wake} = VEC[i][5:1];
      @(negedge clk);
      chk($sformatf("R%0d vector %0d shut", VEC[i][9:6], i), W'(shut), W'(VEC[i][0]));
      chk($sformatf("R%0d vector %0d hold", VEC[i][9:6], i), W'(hold), W'(VEC[i][0]));
    end
    idle();

    chk("R7 code zero", rst_code, 12'h000);
    rst_mid = 1; #1;
    chk("R7 code midscale", rst_code, 12'h800);
    rst_mid = 0;

    // R10 settle window
    @(negedge clk); cmd_sleep = 1;
    @(negedge clk); idle();
    chk("R10 ready low in shutdown", W'(ready), 0);
    cmd_wake = 1;
    @(negedge clk); idle();
    for (int i = 0; i < N; i++) begin
      chk("R10 ready low while settling", W'(ready), 0);
      @(negedge clk);
    end
    chk("R10 ready after settle", W'(ready), 1);

    // R9 user output reset after clear wake
    cmd_sleep = 1;
    @(negedge clk); idle();
    clr_n = 0; #1;
    chk("R6 clr_dac_reg during clear", W'(clr_dac_reg), 1);
    @(negedge clk);
    chk("R9 clr_upo after clear wake", W'(clr_upo), 1);
    chk("R6 shut after clear", W'(shut), 0);
    clr_n = 1;
    @(negedge clk);
    chk("R9 clr_upo one cycle", W'(clr_upo), 0);
    cmd_sleep = 1;
    @(negedge clk); idle();
    cmd_wake = 1;
    @(negedge clk); idle();
    chk("R9 no clr_upo on command wake", W'(clr_upo), 0);
    chk("R5 shut after wake", W'(shut), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule